// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address front end of a pipelined synchronous burst SRAM. On each rising clock edge it looks at two address strobes, a processor-side strobe and a controller-side strobe, and at three chip enables. When a strobe is accepted and the chip is selected, the external word address is captured. The block then produces the array address for a four-beat burst. The upper bits stay fixed for the whole burst. The two low bits are derived from the captured start value and a beat count, which steps whenever the advance input is asserted.

A mode pin, sampled together with the address, chooses one of two beat orders. Linear order counts the low bits modulo four. Interleaved order XORs the start value with the beat number. The processor strobe is gated by the first chip enable: while that enable is inactive the strobe is simply ignored. The controller strobe is never gated this way. When an accepted strobe finds the chip not fully selected, the burst ends.

The outputs are the complete internal array address and a flag that marks a burst in progress. The block does not contain the memory array, the data path or the byte-write logic.

Top module: `bsram_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `burst_act` becomes 0 and `arr_addr` becomes all zeros.
- R2: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. An accepted strobe that finds the chip not selected clears `burst_act` and leaves `arr_addr` unchanged.
- R3: While `ce1_n`=1, a low `adsp_n` has no effect: no load and no deselect take place, and advancing continues as if no strobe were present. A low `adsc_n` still acts.
- R4: After an edge at which a strobe is accepted and the chip is selected, `arr_addr` equals the sampled `addr_in` and `burst_act` is 1. This is beat 0.
- R5: If `seq_linear`=1 was sampled at the load, beat n presents the low two bits as (start + n) mod 4, for example 1,2,3,0.
- R6: If `seq_linear`=0 was sampled at the load, beat n presents the low two bits as start XOR n, for example 2,3,0,1.
- R7: The beat count steps by one at an edge only when `adv_n`=0, `burst_act`=1 and no strobe is accepted. In every other case `arr_addr` holds.
- R8: After the fourth beat, a further advance returns to the start value. Bits above bit 1 of `arr_addr` change only on a load.
- R9: An accepted strobe during a burst abandons that burst and loads the new address at beat 0, even when `adv_n` is low.
- R10: When `adsp_n` and `adsc_n` are both low with `ce1_n`=0, a single load of `addr_in` takes place, with the processor strobe taking priority.
- R11: The beat order is fixed at the load. Changing `seq_linear` during a burst has no effect on the addresses of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External word address |
| adsp_n | input | 1 | Processor-side address strobe, active low, gated by ce1_n |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| seq_linear | input | 1 | Beat order at load: 1 selects linear, 0 selects interleaved |
| arr_addr | output | ADDR_W | Internal array address |
| burst_act | output | 1 | A burst is in progress |

## Verification
The bench builds the block with its defaults: a 17-bit word address and a 2-bit beat field. With these values the all-ones address and the all-zeros address can both be driven and checked at the upper edge of the field. Every start value and both beat orders, including wraps across the four-beat boundary, can be reached within a few cycles. Because the beat field is only two bits wide, a full wrap back to the start value is observed after four advances.

// File: rtl/bsram_seq_pkg.sv
// Shared types of the burst SRAM address sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package bsram_seq_pkg;

    // Beat order captured at the start of a burst.
    typedef enum logic {
        ORD_INTLV  = 1'b0,
        ORD_LINEAR = 1'b1
    } beat_order_e;

    // Action that the strobe decoder requests for the current edge.
    typedef enum logic [1:0] {
        SEQ_NONE  = 2'd0,
        SEQ_LOAD  = 2'd1,
        SEQ_DESEL = 2'd2
    } seq_act_e;

endpackage

// File: rtl/bsram_strobe_dec.sv
// Strobe and chip-enable decoder.
// Turns the two address strobes and three chip enables into one action:
// load, deselect or none. The processor strobe counts only while ce1_n is
// low. The controller strobe always counts.
// Assumes: all inputs are sampled by the consumers on the same edge.
module bsram_strobe_dec
    import bsram_seq_pkg::*;
(
    input  logic     adsp_n,
    input  logic     adsc_n,
    input  logic     ce1_n,
    input  logic     ce2,
    input  logic     ce3_n,
    output seq_act_e act
);

    logic proc_ok;
    logic ctrl_ok;
    logic chip_sel;

    // Qualify each strobe and decode the selection.
    always_comb begin
        proc_ok  = !adsp_n && !ce1_n;
        ctrl_ok  = !adsc_n && !proc_ok;
        chip_sel = !ce1_n && ce2 && !ce3_n;
    end

    // Pick the action for this edge; processor strobe wins when both qualify.
    always_comb begin
        if (proc_ok || ctrl_ok) begin
            act = chip_sel ? SEQ_LOAD : SEQ_DESEL;
        end else begin
            act = SEQ_NONE;
        end
    end

endmodule

// File: rtl/bsram_addr_hold.sv
// Address hold register.
// Captures the upper address bits, the starting low bits and the beat order
// on a load, and keeps them for the whole burst.
// Assumes: act comes from the strobe decoder in the same cycle.
module bsram_addr_hold
    import bsram_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_act_e          act,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              seq_linear,
    output logic [ADDR_W-1:CNT_W] upper_q,
    output logic [CNT_W-1:0]  start_q,
    output beat_order_e       order_q
);

    // Capture the address and order on a load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORD_INTLV;
        end else if (act == SEQ_LOAD) begin
            upper_q <= addr_in[ADDR_W-1:CNT_W];
            start_q <= addr_in[CNT_W-1:0];
            order_q <= seq_linear ? ORD_LINEAR : ORD_INTLV;
        end
    end

endmodule

// File: rtl/bsram_beat_ctr.sv
// Beat counter and burst-active flag.
// Clears the count on a load, clears the flag on a deselect, and otherwise
// steps the count on advance while a burst is active. The count wraps
// modulo 2**CNT_W.
// Assumes: act comes from the strobe decoder in the same cycle.
module bsram_beat_ctr
    import bsram_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_act_e         act,
    input  logic             adv_n,
    output logic [CNT_W-1:0] beat_q,
    output logic             active_q
);

    logic step;

    // Advance only inside a burst and only when no strobe acts.
    always_comb begin
        step = (act == SEQ_NONE) && active_q && !adv_n;
    end

    // Update the count and the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q   <= '0;
            active_q <= 1'b0;
        end else begin
            case (act)
                SEQ_LOAD: begin
                    beat_q   <= '0;
                    active_q <= 1'b1;
                end
                SEQ_DESEL: begin
                    active_q <= 1'b0;
                end
                default: begin
                    if (step) begin
                        beat_q <= beat_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/bsram_addr_seq.sv
// Burst SRAM address sequencer, top level.
// Combines the strobe decoder, the address hold register and the beat
// counter. The low address bits are built from the start value and the
// beat count in either linear or interleaved order.
// Assumes: one clock domain and a synchronous active-low reset.
module bsram_addr_seq
    import bsram_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              seq_linear,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              burst_act
);

    localparam int UP_W = ADDR_W - CNT_W;

    seq_act_e                 act;
    logic [UP_W-1:0]          upper_q;
    logic [CNT_W-1:0]         start_q;
    beat_order_e              order_q;
    logic [CNT_W-1:0]         beat_q;
    logic                     active_q;
    logic [CNT_W-1:0]         lo_lin;
    logic [CNT_W-1:0]         lo_intlv;
    logic [CNT_W-1:0]         lo_sel;

    bsram_strobe_dec u_dec (
        .adsp_n (adsp_n),
        .adsc_n (adsc_n),
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .act    (act)
    );

    bsram_addr_hold #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .addr_in    (addr_in),
        .seq_linear (seq_linear),
        .upper_q    (upper_q),
        .start_q    (start_q),
        .order_q    (order_q)
    );

    bsram_beat_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .adv_n    (adv_n),
        .beat_q   (beat_q),
        .active_q (active_q)
    );

    // Linear order: modular add of the beat count.
    always_comb begin
        lo_lin = start_q + beat_q;
    end

    // Interleaved order: per-bit XOR of start value and beat count.
    for (genvar b = 0; b < CNT_W; b++) begin : g_intlv
        assign lo_intlv[b] = start_q[b] ^ beat_q[b];
    end

    // Select the order captured at load and assemble the outputs.
    always_comb begin
        lo_sel    = (order_q == ORD_LINEAR) ? lo_lin : lo_intlv;
        arr_addr  = {upper_q, lo_sel};
        burst_act = active_q;
    end

endmodule

// File: rtl/bsram_addr_seq_chk.sv
// Assertion checker for the burst SRAM address sequencer, bound to the top.
// Assumes: order_lin is the beat order held inside the top (1 = linear).
module bsram_addr_seq_chk #(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              order_lin,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              burst_act
);

    logic sel;
    logic strobe;

    // Independent view of selection and accepted strobe.
    always_comb begin
        sel    = !ce1_n && ce2 && !ce3_n;
        strobe = (!adsp_n && !ce1_n) || !adsc_n;
    end

    // R4 and R10: a selected strobe loads the sampled address.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && sel) |=> (burst_act && arr_addr == $past(addr_in)));

    // R2: an unselected strobe ends the burst without touching the address.
    p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel) |=> (!burst_act && $stable(arr_addr)));

    // R3: processor strobe blocked by ce1_n, nothing else acting.
    p_adsp_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && adsc_n && adv_n) |=> ($stable(arr_addr) && $stable(burst_act)));

    // R7: no advance and no burst when idle.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_act && adsp_n && adsc_n) |=> (!burst_act && $stable(arr_addr)));

    // R8: upper bits never move without a strobe.
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n) |=> $stable(arr_addr[ADDR_W-1:CNT_W]));

    // R5: linear order steps the low bits by one.
    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && order_lin && adsp_n && adsc_n && !adv_n) |=>
        (arr_addr[CNT_W-1:0] == CNT_W'($past(arr_addr[CNT_W-1:0]) + 1'b1)));

endmodule

bind bsram_addr_seq bsram_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_in   (addr_in),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .adv_n     (adv_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .order_lin (order_q),
    .arr_addr  (arr_addr),
    .burst_act (burst_act)
);

// File: tb/bsram_addr_seq_test.sv
// Self-checking bench for the burst SRAM address sequencer.
module bsram_addr_seq_test;

    localparam int AW = 17;
    localparam int NV = 22;

    typedef struct packed {
        logic          adsp_n;
        logic          adsc_n;
        logic          adv_n;
        logic          ce1_n;
        logic          ce2;
        logic          ce3_n;
        logic          lin;
        logic [AW-1:0] addr;
        logic          e_act;
        logic [AW-1:0] e_addr;
        logic [3:0]    req;
    } vec_t;

    // Fields: adsp_n adsc_n adv_n ce1_n ce2 ce3_n lin addr | exp act, exp addr, req
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,17'h12345, 1'b1,17'h12345, 4'd4},  // R4 processor load
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h12346, 4'd5},  // R5 beat 1
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h12347, 4'd5},  // R5 beat 2
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h12344, 4'd5},  // R5 beat 3
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h12345, 4'd8},  // R8 wrap
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h12345, 4'd7},  // R7 hold
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,17'h0ABCE, 1'b1,17'h0ABCE, 4'd4},  // R4 controller load
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h0ABCF, 4'd11}, // R11 pin flip ignored
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h0ABCC, 4'd6},  // R6 beat 2
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h0ABCD, 4'd6},  // R6 beat 3
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,17'h00000, 1'b1,17'h0ABCE, 4'd8},  // R8 interleaved wrap
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,17'h1FFFF, 1'b1,17'h0ABCE, 4'd3},  // R3 blocked, no load
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,17'h1FFFF, 1'b1,17'h0ABCF, 4'd3},  // R3 blocked, advance goes on
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,17'h1FFFF, 1'b0,17'h0ABCF, 4'd3},  // R3 controller still acts
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b0,17'h0ABCF, 4'd7},  // R7 idle advance ignored
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,17'h00003, 1'b1,17'h00003, 4'd4},  // R4 load from idle
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,17'h1FFFF, 1'b0,17'h00003, 4'd2},  // R2 ce3_n high
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,17'h1FFFE, 1'b1,17'h1FFFE, 4'd10}, // R10 both strobes
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h1FFFF, 4'd5},  // R5 step
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00001, 1'b1,17'h00001, 4'd9},  // R9 restart beats advance
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,17'h00000, 1'b1,17'h00002, 4'd5},  // R5 step
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,17'h1FFFF, 1'b0,17'h00002, 4'd2}   // R2 ce2 low
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          adsp_n = 1'b1;
    logic          adsc_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ce1_n = 1'b0;
    logic          ce2 = 1'b1;
    logic          ce3_n = 1'b0;
    logic          seq_linear = 1'b1;
    logic [AW-1:0] arr_addr;
    logic          burst_act;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bsram_addr_seq #(.ADDR_W(AW), .CNT_W(2)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (addr_in),
        .adsp_n     (adsp_n),
        .adsc_n     (adsc_n),
        .adv_n      (adv_n),
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .seq_linear (seq_linear),
        .arr_addr   (arr_addr),
        .burst_act  (burst_act)
    );

    task automatic check(input string tag, input logic ea, input logic [AW-1:0] eaddr);
        n_chk++;
        if (burst_act !== ea || arr_addr !== eaddr) begin
            n_err++;
            $display("FAIL %s: act=%0b addr=%h expected act=%0b addr=%h",
                     tag, burst_act, arr_addr, ea, eaddr);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        adsp_n     = v.adsp_n;
        adsc_n     = v.adsc_n;
        adv_n      = v.adv_n;
        ce1_n      = v.ce1_n;
        ce2        = v.ce2;
        ce3_n      = v.ce3_n;
        seq_linear = v.lin;
        addr_in    = v.addr;
        @(posedge clk);
        #1;
    endtask

    function automatic vec_t mk(input logic p, input logic c, input logic a,
                                input logic [AW-1:0] ad, input logic ln);
        vec_t v;
        v = '0;
        v.adsp_n = p; v.adsc_n = c; v.adv_n = a;
        v.ce1_n = 1'b0; v.ce2 = 1'b1; v.ce3_n = 1'b0;
        v.lin = ln; v.addr = ad;
        return v;
    endfunction

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: state under reset
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].e_act, VEC[i].e_addr);
        end

        // R5: linear start at 3 wraps through 0
        drive(mk(1'b0, 1'b1, 1'b1, 17'h00007, 1'b1));
        check("R4 load 7", 1'b1, 17'h00007);
        drive(mk(1'b1, 1'b1, 1'b0, 17'h00000, 1'b1));
        check("R5 wrap 3->0", 1'b1, 17'h00004);

        // R6: interleaved start at 1 gives 1,0,3,2
        drive(mk(1'b0, 1'b1, 1'b1, 17'h10001, 1'b0));
        check("R6 load", 1'b1, 17'h10001);
        drive(mk(1'b1, 1'b1, 1'b0, 17'h00000, 1'b0));
        check("R6 beat 1", 1'b1, 17'h10000);
        drive(mk(1'b1, 1'b1, 1'b0, 17'h00000, 1'b0));
        check("R6 beat 2", 1'b1, 17'h10003);

        // R1: reset in the middle of a burst
        @(negedge clk);
        rst_n = 1'b0;
        adv_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-burst", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: advance after reset does nothing
        drive(mk(1'b1, 1'b1, 1'b0, 17'h1FFFF, 1'b1));
        check("R7 idle after reset", 1'b0, '0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule